// File: doc/BRIEF.md
# 8-bit Arithmetic-Logic Unit with Condition Flags

This block is the data-path arithmetic unit of a small 8-bit RISC core. It is purely combinational. It takes two operands, an incoming carry, the current zero flag and a 5-bit operation code. The caller places either a register or an immediate on operand B. The block returns the result byte and a six-bit condition word. It also returns a six-bit write-enable mask, which tells the status register which of those flags the operation updates. Flags that are not written are kept by the status register.

The operation set covers plain and carry-chained add and subtract, AND/OR/XOR, inversion and negation, increment and decrement, single-bit logical and arithmetic shifts, rotates through carry, and nibble exchange. The subtract-with-carry operation can only keep or clear the zero flag. Because of this, a comparison spread over several bytes yields a correct equality result.

Top module: `alu8_core`

## Requirements
- R1: Opcode encoding on `alu_op`: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 OR, 6 XOR, 7 invert, 8 negate, 9 increment, 10 decrement, 11 shift left, 12 logical shift right, 13 rotate left, 14 rotate right, 15 arithmetic shift right, 16 nibble swap. Add and subtract results are taken modulo 256. The carry-in variants add `carry_in` or subtract it.
- R2: Bit positions in `flags` and `flag_we`: bit 0 zero (Z), 1 carry (C), 2 negative (N), 3 overflow (V), 4 half carry (H), 5 sign (S). Any flag bit whose `flag_we` bit is 0 reads as 0.
- R3: Add and subtract, with or without carry, write all six flags (mask 0x3F). On an add, C is the carry out of bit 7 and H the carry out of bit 3. On a subtract, C is the borrow out of bit 7 and H the borrow into bit 4. V is set on a signed overflow.
- R4: For subtract with carry, Z is 1 only if the result is zero and `zero_in` is 1. For every other operation that writes Z, Z is 1 exactly when the result is zero.
- R5: AND, OR and XOR write only Z, N, V and S (mask 0x2D), and V is 0.
- R6: Invert returns 0xFF minus A, sets C to 1 and V to 0, and uses mask 0x2F. Negate returns 0x00 minus A and writes all six flags with subtract semantics.
- R7: Increment and decrement change A by one and use mask 0x2D. V is set when A is 0x7F on increment, or 0x80 on decrement.
- R8: Shift left moves 0 into bit 0 and bit 7 into C. Logical shift right moves 0 into bit 7 and bit 0 into C. All shifts and rotates use mask 0x2F, with V = N xor C.
- R9: Rotate left sends bit 7 to C and `carry_in` to bit 0. Rotate right sends bit 0 to C and `carry_in` to bit 7.
- R10: Arithmetic shift right keeps bit 7, shifts bits 7..1 down by one place, and moves bit 0 into C.
- R11: Nibble swap exchanges the upper and lower halves of A and writes no flag (mask 0).
- R12: S equals N xor V for every operation that writes V.
- R13: Opcodes 17 to 31 return result 0 and mask 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 5 | Operation code (R1 encoding) |
| opnd_a | input | 8 | Operand A (destination register value) |
| opnd_b | input | 8 | Operand B (register or immediate) |
| carry_in | input | 1 | Current carry flag |
| zero_in | input | 1 | Current zero flag, used by subtract with carry |
| result | output | 8 | Result byte |
| flags | output | 6 | Computed flags, masked by flag_we |
| flag_we | output | 6 | Per-flag write enable for the status register |

## Verification
Every output is a pure function of the present inputs, so a result is due in the cycle its stimulus is applied, with zero register stages. The bench changes the inputs just after a rising edge and reads the outputs at the following falling edge, half a period later, when the logic has settled. The expected values come from a fixed vector table and from an integer reference model. That model works out carries, borrows and signed overflow by range tests rather than bit equations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  parameter int DW = 8;
  localparam int OPW = 5;
  localparam int NFLAG = 6;
  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FH = 4;
  localparam int FS = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_COM  = 5'd7,
    OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_LSL  = 5'd11,
    OP_LSR  = 5'd12, OP_ROL  = 5'd13, OP_ROR  = 5'd14, OP_ASR  = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;

  localparam logic [NFLAG-1:0] MASK_ALL   = 6'h3F;
  localparam logic [NFLAG-1:0] MASK_LOGIC = 6'h2D;
  localparam logic [NFLAG-1:0] MASK_SHIFT = 6'h2F;

  function automatic logic [NFLAG-1:0] write_mask(input logic [OPW-1:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:   write_mask = MASK_ALL;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:    write_mask = MASK_LOGIC;
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR,
      OP_ASR:                                   write_mask = MASK_SHIFT;
      default:                                  write_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         hout,
  output logic         vout
);
  localparam int HW = W / 2;

  logic [W-1:0]  y_eff;
  logic          c_eff;
  logic [W:0]    full;
  logic [HW:0]   low;

  always_comb begin
    y_eff = sub ? ~y : y;
    c_eff = sub ? ~cin : cin;
    full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
    low   = {1'b0, x[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
    sum   = full[W-1:0];
    cout  = full[W] ^ sub;
    hout  = low[HW] ^ sub;
    vout  = (x[W-1] == y_eff[W-1]) && (full[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      kind,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res
);
  always_comb begin
    case (kind)
      OP_AND:  res = x & y;
      OP_OR:   res = x | y;
      OP_XOR:  res = x ^ y;
      OP_COM:  res = ~x;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      kind,
  input  logic [W-1:0] x,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int HW = W / 2;

  always_comb begin
    res  = '0;
    cout = 1'b0;
    case (kind)
      OP_LSL: begin res = {x[W-2:0], 1'b0};    cout = x[W-1]; end
      OP_LSR: begin res = {1'b0, x[W-1:1]};    cout = x[0];   end
      OP_ROL: begin res = {x[W-2:0], cin};     cout = x[W-1]; end
      OP_ROR: begin res = {cin, x[W-1:1]};     cout = x[0];   end
      OP_ASR: begin res = {x[W-1], x[W-1:1]};  cout = x[0];   end
      OP_SWAP: res = {x[HW-1:0], x[W-1:HW]};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = alu8_pkg::DW
) (
  input  logic [OPW-1:0]   alu_op,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic             carry_in,
  input  logic             zero_in,
  output logic [W-1:0]     result,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] flag_we
);
  alu_op_e op;
  assign op = alu_op_e'(alu_op);

  logic [W-1:0] as_x, as_y, as_sum;
  logic         as_cin, as_sub, as_c, as_h, as_v;
  logic [W-1:0] bw_res, sh_res;
  logic         sh_c;

  always_comb begin
    as_x   = opnd_a;
    as_y   = opnd_b;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADC: as_cin = carry_in;
      OP_SUB: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_cin = carry_in; end
      OP_NEG: begin as_sub = 1'b1; as_x = '0; as_y = opnd_a; end
      OP_INC: as_y = W'(1);
      OP_DEC: begin as_sub = 1'b1; as_y = W'(1); end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .cout(as_c), .hout(as_h), .vout(as_v)
  );

  alu8_bitwise #(.W(W)) u_bitwise (
    .kind(op), .x(opnd_a), .y(opnd_b), .res(bw_res)
  );

  alu8_shifter #(.W(W)) u_shifter (
    .kind(op), .x(opnd_a), .cin(carry_in), .res(sh_res), .cout(sh_c)
  );

  logic [W-1:0]     res_nxt;
  logic             c_nxt, h_nxt, v_nxt, n_nxt, z_nxt;
  logic [NFLAG-1:0] raw;
  logic [NFLAG-1:0] we_nxt;

  always_comb begin
    res_nxt = '0;
    c_nxt   = 1'b0;
    h_nxt   = 1'b0;
    v_nxt   = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC: begin
        res_nxt = as_sum;
        c_nxt   = as_c;
        h_nxt   = as_h;
        v_nxt   = as_v;
      end
      OP_AND, OP_OR, OP_XOR: res_nxt = bw_res;
      OP_COM: begin
        res_nxt = bw_res;
        c_nxt   = 1'b1;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        res_nxt = sh_res;
        c_nxt   = sh_c;
        v_nxt   = sh_res[W-1] ^ sh_c;
      end
      OP_SWAP: res_nxt = sh_res;
      default: ;
    endcase
    n_nxt = res_nxt[W-1];
    z_nxt = (res_nxt == '0) && ((op != OP_SBC) || zero_in);
    raw        = '0;
    raw[FZ]    = z_nxt;
    raw[FC]    = c_nxt;
    raw[FN]    = n_nxt;
    raw[FV]    = v_nxt;
    raw[FH]    = h_nxt;
    raw[FS]    = n_nxt ^ v_nxt;
    we_nxt     = write_mask(alu_op);
  end

  assign result  = res_nxt;
  assign flags   = raw & we_nxt;
  assign flag_we = we_nxt;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = alu8_pkg::DW
) (
  input logic [OPW-1:0]   alu_op,
  input logic [W-1:0]     opnd_a,
  input logic             zero_in,
  input logic [W-1:0]     result,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] flag_we
);
  always_comb begin
    AST_MASKED_CLEAR: assert ((flags & ~flag_we) == '0) else $error("masked flag set"); // R2
    if (flag_we[FV])
      AST_SIGN_RULE: assert (flags[FS] == (flags[FN] ^ flags[FV])) else $error("S != N^V"); // R12
    if (alu_op == OP_SBC && !zero_in)
      AST_SBC_ZERO_STICKY: assert (!flags[FZ]) else $error("SBC set Z"); // R4
    if (flag_we[FZ] && alu_op != OP_SBC)
      AST_ZERO_MATCH: assert (flags[FZ] == (result == '0)) else $error("Z mismatch"); // R4
    if (alu_op == OP_INC || alu_op == OP_DEC)
      AST_INCDEC_NO_CARRY: assert (!flag_we[FC] && !flag_we[FH]) else $error("inc/dec carry"); // R7
    if (alu_op == OP_SWAP)
      AST_SWAP_NO_FLAGS: assert (flag_we == '0 && result == {opnd_a[W/2-1:0], opnd_a[W-1:W/2]})
        else $error("swap"); // R11
    if (alu_op > OP_SWAP)
      AST_UNUSED_OP: assert (flag_we == '0 && result == '0) else $error("unused op"); // R13
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .alu_op(alu_op), .opnd_a(opnd_a), .zero_in(zero_in),
  .result(result), .flags(flags), .flag_we(flag_we)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk;
  logic [4:0] alu_op;
  logic [7:0] opnd_a, opnd_b, result;
  logic       carry_in, zero_in;
  logic [5:0] flags, flag_we;
  int total = 0;
  int bad = 0;
  bit done = 0;

  alu8_core uut (
    .alu_op(alu_op), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
    .zero_in(zero_in), .result(result), .flags(flags), .flag_we(flag_we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {req, op, a, b, cin, zin, exp_res, exp_flags, exp_mask}
  localparam int NV = 20;
  localparam logic [46:0] VEC [NV] = '{
    {4'd3,  5'd0,  8'h0F, 8'h01, 1'b0, 1'b0, 8'h10, 6'h10, 6'h3F}, // R3 half carry
    {4'd3,  5'd0,  8'h80, 8'h80, 1'b0, 1'b0, 8'h00, 6'h2B, 6'h3F}, // R3 carry+overflow
    {4'd1,  5'd1,  8'h7F, 8'h00, 1'b1, 1'b0, 8'h80, 6'h1C, 6'h3F}, // R1 carry chain
    {4'd3,  5'd2,  8'h00, 8'h01, 1'b0, 1'b0, 8'hFF, 6'h36, 6'h3F}, // R3 borrow
    {4'd4,  5'd3,  8'h05, 8'h05, 1'b0, 1'b0, 8'h00, 6'h00, 6'h3F}, // R4 Z kept clear
    {4'd4,  5'd3,  8'h05, 8'h05, 1'b0, 1'b1, 8'h00, 6'h01, 6'h3F}, // R4 Z kept set
    {4'd5,  5'd4,  8'hF0, 8'h3C, 1'b1, 1'b0, 8'h30, 6'h00, 6'h2D}, // R5 and
    {4'd5,  5'd6,  8'hAA, 8'hAA, 1'b0, 1'b0, 8'h00, 6'h01, 6'h2D}, // R5 xor
    {4'd12, 5'd5,  8'h80, 8'h01, 1'b0, 1'b0, 8'h81, 6'h24, 6'h2D}, // R12 or
    {4'd6,  5'd7,  8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 6'h26, 6'h2F}, // R6 invert
    {4'd6,  5'd8,  8'h80, 8'h00, 1'b0, 1'b0, 8'h80, 6'h0E, 6'h3F}, // R6 negate
    {4'd7,  5'd9,  8'h7F, 8'h00, 1'b1, 1'b0, 8'h80, 6'h0C, 6'h2D}, // R7 inc
    {4'd7,  5'd10, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 6'h24, 6'h2D}, // R7 dec
    {4'd8,  5'd11, 8'h81, 8'h00, 1'b0, 1'b0, 8'h02, 6'h2A, 6'h2F}, // R8 shl
    {4'd8,  5'd12, 8'h01, 8'h00, 1'b1, 1'b0, 8'h00, 6'h2B, 6'h2F}, // R8 shr
    {4'd9,  5'd14, 8'h02, 8'h00, 1'b1, 1'b0, 8'h81, 6'h0C, 6'h2F}, // R9 ror
    {4'd9,  5'd13, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 6'h2B, 6'h2F}, // R9 rol
    {4'd10, 5'd15, 8'h81, 8'h00, 1'b0, 1'b0, 8'hC0, 6'h26, 6'h2F}, // R10 asr
    {4'd11, 5'd16, 8'h3C, 8'h00, 1'b1, 1'b1, 8'hC3, 6'h00, 6'h00}, // R11 swap
    {4'd13, 5'd31, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'h00, 6'h00, 6'h00}  // R13 unused
  };

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Integer reference: returns {res, flags, mask}
  function automatic logic [19:0] ref_model(input int op, input int a, input int b,
                                            input int ci, input int zi);
    int r, c, h, v, n, z, m, x, y, k, t;
    bit sub;
    r = 0; c = 0; h = 0; v = 0; m = 0; x = a; y = b; k = 0; sub = 0;
    case (op)
      0, 1, 9: begin
        if (op == 1) k = ci;
        if (op == 9) begin y = 1; k = 0; end
      end
      2, 3, 8, 10: begin
        sub = 1;
        if (op == 3) k = ci;
        if (op == 8) begin x = 0; y = a; end
        if (op == 10) y = 1;
      end
      default: ;
    endcase
    case (op)
      0, 1, 9, 2, 3, 8, 10: begin
        if (!sub) begin
          t = x + y + k; c = (t > 255); h = ((x % 16) + (y % 16) + k) > 15;
          v = ((sx(x) + sx(y) + k) > 127) || ((sx(x) + sx(y) + k) < -128);
        end else begin
          t = x - y - k; c = (t < 0); h = ((x % 16) - (y % 16) - k) < 0;
          v = ((sx(x) - sx(y) - k) > 127) || ((sx(x) - sx(y) - k) < -128);
        end
        r = (t + 256) % 256;
        m = (op == 9 || op == 10) ? 'h2D : 'h3F;
      end
      4: begin r = a & b; m = 'h2D; end
      5: begin r = a | b; m = 'h2D; end
      6: begin r = a ^ b; m = 'h2D; end
      7: begin r = 255 - a; c = 1; m = 'h2F; end
      11: begin r = (a * 2) % 256; c = a / 128; m = 'h2F; end
      12: begin r = a / 2; c = a % 2; m = 'h2F; end
      13: begin r = (a * 2) % 256 + ci; c = a / 128; m = 'h2F; end
      14: begin r = a / 2 + ci * 128; c = a % 2; m = 'h2F; end
      15: begin r = a / 2 + (a / 128) * 128; c = a % 2; m = 'h2F; end
      16: begin r = (a % 16) * 16 + a / 16; m = 0; end
      default: ;
    endcase
    n = r / 128;
    if (op >= 11 && op <= 15) v = n ^ c;
    z = (r == 0) && (op != 3 || zi == 1);
    t = (((n ^ v) & 1) << 5) | (h << 4) | (v << 3) | (n << 2) | (c << 1) | z;
    t = t & m;
    return {r[7:0], t[5:0], m[5:0]};
  endfunction

  function automatic int req_of(input int op);
    case (op)
      0, 1, 2, 3: return 3;
      4, 5, 6: return 5;
      7, 8: return 6;
      9, 10: return 7;
      11, 12: return 8;
      13, 14: return 9;
      15: return 10;
      16: return 11;
      default: return 13;
    endcase
  endfunction

  task automatic check(input int req, input logic [7:0] er, input logic [5:0] ef,
                       input logic [5:0] em);
    total++;
    if (result !== er || flags !== ef || flag_we !== em) begin
      bad++;
      $display("FAIL R%0d op=%0d a=%h b=%h: got res=%h flags=%h we=%h, expected res=%h flags=%h we=%h",
               req, alu_op, opnd_a, opnd_b, result, flags, flag_we, er, ef, em);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic ci, input logic zi);
    @(posedge clk);
    alu_op = op; opnd_a = a; opnd_b = b; carry_in = ci; zero_in = zi;
    @(negedge clk); // combinational: due in the same cycle
  endtask

  initial begin
    logic [19:0] exp_v;
    alu_op = '0; opnd_a = '0; opnd_b = '0; carry_in = 1'b0; zero_in = 1'b0;
    repeat (2) @(posedge clk);
    // R1 idle state: add of zeros gives zero with Z only
    apply(5'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    check(1, 8'h00, 6'h01, 6'h3F);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][42:38], VEC[i][37:30], VEC[i][29:22], VEC[i][21], VEC[i][20]);
      check(int'(VEC[i][46:43]), VEC[i][19:12], VEC[i][11:6], VEC[i][5:0]);
    end
    // R12 R2: random sweep of every opcode against the reference
    for (int i = 0; i < 3000; i++) begin
      int op, a, b, ci, zi;
      op = i % 17; a = $urandom % 256; b = $urandom % 256;
      ci = $urandom % 2; zi = $urandom % 2;
      apply(op[4:0], a[7:0], b[7:0], ci[0], zi[0]);
      exp_v = ref_model(op, a, b, ci, zi);
      check(req_of(op), exp_v[19:12], exp_v[11:6], exp_v[5:0]);
    end
    // R13: every unused opcode
    for (int op = 17; op < 32; op++) begin
      apply(op[4:0], 8'h5A, 8'hA5, 1'b1, 1'b1);
      check(13, 8'h00, 6'h00, 6'h00);
    end
    // R9 R4 corners: rotate with carry in both ways, SBC chain low then high byte
    apply(5'd13, 8'h00, 8'h00, 1'b1, 1'b0);
    check(9, 8'h01, 6'h00, 6'h2F);
    apply(5'd3, 8'h12, 8'h11, 1'b0, 1'b1);
    check(4, 8'h01, 6'h00, 6'h3F);
    apply(5'd3, 8'h00, 8'h00, 1'b1, 1'b1);
    check(4, 8'hFF, 6'h36, 6'h3F);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule